// File: doc/BRIEF.md
# Counter Read Permission Checker

This block sits beside the CSR access stage of a processor pipeline. For every CSR instruction it makes one decision: may the access go ahead, or must it raise an illegal-instruction exception? The block reads the current privilege mode, the 12-bit CSR number and the operation kind. It checks the access against the CSR number's own privilege and read-only fields. For the counter window (0xC00 to 0xC1F) it also checks a per-counter enable bit. The enable bits are held in two registers inside the block: a machine-level one and a supervisor-level one. The decision never looks at the data word the instruction carries.

Both enable registers are CSRs in their own right. The machine one sits at 0x306 and the supervisor one at 0x106. The block applies legal writes, sets and clears to them on the next clock edge, and it returns their contents for legal accesses. A read that the block allows in the counter window also raises a read strobe that the counter bank uses. The counters themselves, instruction decode and trap delivery live elsewhere.

Top module: `cntacc_top`

## Requirements
- R1: After reset both enable registers read zero. While `csr_valid` is low, `illegal_insn`, `cnt_rd_en` and `en_rdata` are all zero and no register changes.
- R2: Machine mode (`cur_priv` = 3) may always read a counter (address 0xC00 + index), whatever the enable bits hold, and `cnt_rd_en` rises for it.
- R3: A supervisor-mode (`cur_priv` = 1) counter read is legal exactly when the machine enable bit at the counter's index (address bits [4:0]) is set.
- R4: When supervisor mode is implemented, a user-mode (`cur_priv` = 0) counter read is legal only if both the machine and the supervisor enable bits at that index are set.
- R5: When supervisor mode is not implemented, a user-mode counter read is legal exactly when the machine enable bit is set.
- R6: Any operation other than read-only (`csr_op` not 0) to an address whose bits [11:10] are 2'b11 is illegal in every mode, whatever the data and the enable bits.
- R7: An access is illegal when address bits [9:8] encode a privilege above `cur_priv`.
- R8: The mode encoding 2 is illegal for every access. So is encoding 1 when supervisor mode is not implemented.
- R9: `csr_op` encodes 0 = read only, 1 = write, 2 = set bits, 3 = clear bits. A legal non-read operation to an enable register takes effect at the next clock edge. An illegal one leaves both registers unchanged.
- R10: Enable bits whose position is clear in the parameter `CNT_MASK` always read zero.
- R11: `en_rdata` returns the addressed enable register, as it stood before the edge, on a legal access to 0x306 or 0x106. It is zero otherwise.
- R12: When supervisor mode is not implemented, any access to the supervisor enable register (0x106) is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | A CSR instruction is presented this cycle |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_addr | input | 12 | CSR number |
| csr_op | input | 2 | 0 read only, 1 write, 2 set, 3 clear |
| csr_wdata | input | NCNT | Operand for enable register updates |
| illegal_insn | output | 1 | The access must trap as an illegal instruction |
| cnt_rd_en | output | 1 | Legal read of the counter picked by the address |
| en_rdata | output | NCNT | Read value of an addressed enable register |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. One copy has supervisor mode and a full mask. It covers the two-level chain, where user reads need both bits. The other copy has no supervisor mode and a sparse mask of 0x800000F7. It reaches the user-reads-on-machine-bit-only path, the rejection of mode 1 and of the absent register, and the enable bits that are tied to zero. A behavioural model in the bench tracks the enable contents of both copies and predicts every output on every cycle.

// File: rtl/cntacc_pkg.sv
package cntacc_pkg;

    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_SET = 2'd2,
        OP_CLR = 2'd3
    } csr_op_e;

    localparam int unsigned ADDR_W = 12;

    // Classification of one CSR number, produced by the decoder.
    typedef struct packed {
        logic       ro;        // number lies in a read-only range
        logic [1:0] min_priv;  // lowest privilege allowed
        logic       cnt;       // inside the counter window
        logic       men;       // machine enable register
        logic       sen;       // supervisor enable register
    } addr_class_t;

endpackage

// File: rtl/cntacc_decode.sv
module cntacc_decode
    import cntacc_pkg::*;
#(
    parameter int unsigned NCNT     = 32,
    parameter logic [11:0] CNT_BASE = 12'hC00,
    parameter logic [11:0] MEN_ADDR = 12'h306,
    parameter logic [11:0] SEN_ADDR = 12'h106,
    localparam int unsigned IDXW    = $clog2(NCNT)
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_t       cls,
    output logic [IDXW-1:0]   idx
);

    // NCNT must be a power of two so the window is an aligned block.
    always_comb begin
        cls          = '0;
        cls.ro       = (addr[11:10] == 2'b11);
        cls.min_priv = addr[9:8];
        cls.cnt      = (addr[ADDR_W-1:IDXW] == CNT_BASE[ADDR_W-1:IDXW]);
        cls.men      = (addr == MEN_ADDR);
        cls.sen      = (addr == SEN_ADDR);
        idx          = addr[IDXW-1:0];
    end

endmodule

// File: rtl/cntacc_judge.sv
module cntacc_judge
    import cntacc_pkg::*;
#(
    parameter int unsigned NCNT   = 32,
    parameter bit          HAS_S  = 1'b1,
    localparam int unsigned IDXW  = $clog2(NCNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [1:0]      priv,
    input  logic [1:0]      op,
    input  addr_class_t     cls,
    input  logic [IDXW-1:0] idx,
    input  logic [NCNT-1:0] men_q,
    input  logic [NCNT-1:0] sen_q,
    output logic            illegal,
    output logic            cnt_rd,
    output logic            legal_wr
);

    logic mode_bad, priv_low, ro_wr, absent, cnt_block, any_bad;
    logic m_bit, s_bit;

    always_comb begin
        m_bit     = men_q[idx];
        s_bit     = sen_q[idx];
        mode_bad  = (priv == PRV_RSV) || (!HAS_S && priv == PRV_S);
        priv_low  = (priv < cls.min_priv);
        ro_wr     = cls.ro && (op != OP_RD);
        absent    = cls.sen && !HAS_S;
        cnt_block = 1'b0;
        if (cls.cnt && priv != PRV_M) begin
            if (!m_bit) cnt_block = 1'b1;
            if (HAS_S && priv == PRV_U && !s_bit) cnt_block = 1'b1;
        end
        any_bad  = mode_bad | priv_low | ro_wr | absent | cnt_block;
        illegal  = valid && any_bad;
        cnt_rd   = valid && !any_bad && cls.cnt;
        legal_wr = valid && !any_bad && (op != OP_RD);
    end

    // R6
    ro_write_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cls.ro && op != OP_RD) |-> illegal);

    // R2
    mach_counter_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRV_M && cls.cnt && op == OP_RD && cls.min_priv == 2'b00)
            |-> (cnt_rd && !illegal));

    // R3
    sup_needs_mbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && priv == PRV_S && cls.cnt && !men_q[idx]) |-> illegal);

    // R4
    user_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_S && valid && priv == PRV_U && cls.cnt && !sen_q[idx]) |-> !cnt_rd);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (!illegal && !cnt_rd));

endmodule

// File: rtl/cntacc_enreg.sv
module cntacc_enreg
    import cntacc_pkg::*;
#(
    parameter int unsigned  NCNT     = 32,
    parameter bit           HAS_S    = 1'b1,
    parameter logic [NCNT-1:0] CNT_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_men,
    input  logic            wr_sen,
    input  logic [1:0]      op,
    input  logic [NCNT-1:0] wdata,
    output logic [NCNT-1:0] men_q,
    output logic [NCNT-1:0] sen_q
);

    localparam logic [NCNT-1:0] SEN_MASK = HAS_S ? CNT_MASK : '0;

    typedef struct packed {
        logic [NCNT-1:0] men;
        logic [NCNT-1:0] sen;
    } en_st_t;

    en_st_t st_d, st_q;

    function automatic logic [NCNT-1:0] apply_op(
        input logic [NCNT-1:0] old,
        input logic [1:0]      o,
        input logic [NCNT-1:0] d
    );
        unique case (o)
            OP_WR:   apply_op = d;
            OP_SET:  apply_op = old | d;
            OP_CLR:  apply_op = old & ~d;
            default: apply_op = old;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_men) st_d.men = apply_op(st_q.men, op, wdata) & CNT_MASK;
        if (wr_sen) st_d.sen = apply_op(st_q.sen, op, wdata) & SEN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign men_q = st_q.men;
    assign sen_q = st_q.sen;

    // R10
    masked_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((men_q & ~CNT_MASK) == '0) && ((sen_q & ~SEN_MASK) == '0));

    // R9
    no_update_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_men && !wr_sen) |=> ($stable(men_q) && $stable(sen_q)));

endmodule

// File: rtl/cntacc_top.sv
module cntacc_top
    import cntacc_pkg::*;
#(
    parameter int unsigned     NCNT     = 32,
    parameter bit              HAS_S    = 1'b1,
    parameter logic [NCNT-1:0] CNT_MASK = '1,
    localparam int unsigned    IDXW     = $clog2(NCNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_valid,
    input  logic [1:0]      cur_priv,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_op,
    input  logic [NCNT-1:0] csr_wdata,
    output logic            illegal_insn,
    output logic            cnt_rd_en,
    output logic [NCNT-1:0] en_rdata
);

    addr_class_t     cls;
    logic [IDXW-1:0] idx;
    logic [NCNT-1:0] men_q, sen_q;
    logic            legal_wr, legal_acc;

    cntacc_decode #(.NCNT(NCNT)) u_dec (
        .addr (csr_addr),
        .cls  (cls),
        .idx  (idx)
    );

    cntacc_judge #(.NCNT(NCNT), .HAS_S(HAS_S)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (csr_valid),
        .priv     (cur_priv),
        .op       (csr_op),
        .cls      (cls),
        .idx      (idx),
        .men_q    (men_q),
        .sen_q    (sen_q),
        .illegal  (illegal_insn),
        .cnt_rd   (cnt_rd_en),
        .legal_wr (legal_wr)
    );

    cntacc_enreg #(.NCNT(NCNT), .HAS_S(HAS_S), .CNT_MASK(CNT_MASK)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_men (legal_wr && cls.men),
        .wr_sen (legal_wr && cls.sen),
        .op     (csr_op),
        .wdata  (csr_wdata),
        .men_q  (men_q),
        .sen_q  (sen_q)
    );

    always_comb begin
        legal_acc = csr_valid && !illegal_insn;
        en_rdata  = '0;
        if (legal_acc && cls.men)      en_rdata = men_q;
        else if (legal_acc && cls.sen) en_rdata = sen_q;
    end

    // R9
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && illegal_insn) |=> ($stable(men_q) && $stable(sen_q)));

    // R8
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && cur_priv == 2'd2) |-> illegal_insn);

endmodule

// File: tb/sim_cntacc_top.sv
module sim_cntacc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [1:0]  cur_priv = 2'd3;
    logic [11:0] csr_addr = 12'h0;
    logic [1:0]  csr_op = 2'd0;
    logic [31:0] csr_wdata = 32'h0;
    logic        ill0, rd0, ill1, rd1;
    logic [31:0] rdat0, rdat1;

    localparam logic [31:0] MASK1 = 32'h8000_00F7;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_men0 = '0, m_sen0 = '0, m_men1 = '0, m_sen1 = '0;

    always #4 clk = ~clk;

    cntacc_top #(.NCNT(32), .HAS_S(1'b1), .CNT_MASK(32'hFFFF_FFFF)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .cur_priv(cur_priv),
        .csr_addr(csr_addr), .csr_op(csr_op), .csr_wdata(csr_wdata),
        .illegal_insn(ill0), .cnt_rd_en(rd0), .en_rdata(rdat0));

    cntacc_top #(.NCNT(32), .HAS_S(1'b0), .CNT_MASK(MASK1)) u1 (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .cur_priv(cur_priv),
        .csr_addr(csr_addr), .csr_op(csr_op), .csr_wdata(csr_wdata),
        .illegal_insn(ill1), .cnt_rd_en(rd1), .en_rdata(rdat1));

    function automatic bit m_illegal(bit has_s, int priv, int addr, int op,
                                     logic [31:0] men, logic [31:0] sen);
        int idx;
        bit cnt;
        idx = addr % 32;
        cnt = (addr / 32) == (12'hC00 / 32);
        if (priv == 2 || (!has_s && priv == 1)) return 1'b1;   // R8
        if (priv < ((addr / 256) % 4)) return 1'b1;            // R7
        if (((addr / 1024) % 4) == 3 && op != 0) return 1'b1;  // R6
        if (!has_s && addr == 12'h106) return 1'b1;            // R12
        if (cnt && priv != 3) begin
            if (!men[idx]) return 1'b1;                        // R3
            if (has_s && priv == 0 && !sen[idx]) return 1'b1;  // R4
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_apply(logic [31:0] old, int op, logic [31:0] d);
        if (op == 1) return d;
        if (op == 2) return old | d;
        if (op == 3) return old & ~d;
        return old;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit v, int priv, int addr, int op, logic [31:0] d);
        bit e_ill0, e_ill1, cnt;
        logic [31:0] e_rd0, e_rd1;
        @(negedge clk);
        csr_valid = v; cur_priv = priv[1:0]; csr_addr = addr[11:0];
        csr_op = op[1:0]; csr_wdata = d;
        #1;
        cnt = (addr / 32) == (12'hC00 / 32);
        e_ill0 = v && m_illegal(1'b1, priv, addr, op, m_men0, m_sen0);
        e_ill1 = v && m_illegal(1'b0, priv, addr, op, m_men1, m_sen1);
        e_rd0 = '0; e_rd1 = '0;
        if (v && !e_ill0 && addr == 12'h306) e_rd0 = m_men0;
        if (v && !e_ill0 && addr == 12'h106) e_rd0 = m_sen0;
        if (v && !e_ill1 && addr == 12'h306) e_rd1 = m_men1;
        chk({tag, " u0 illegal"}, {31'd0, ill0}, {31'd0, e_ill0});
        chk({tag, " u0 cnt_rd"},  {31'd0, rd0},  {31'd0, v && !e_ill0 && cnt});
        chk({tag, " u0 rdata"},   rdat0, e_rd0);
        chk({tag, " u1 illegal"}, {31'd0, ill1}, {31'd0, e_ill1});
        chk({tag, " u1 cnt_rd"},  {31'd0, rd1},  {31'd0, v && !e_ill1 && cnt});
        chk({tag, " u1 rdata"},   rdat1, e_rd1);
        @(posedge clk);
        if (v && !e_ill0 && op != 0) begin
            if (addr == 12'h306) m_men0 = m_apply(m_men0, op, d);
            if (addr == 12'h106) m_sen0 = m_apply(m_sen0, op, d);
        end
        if (v && !e_ill1 && op != 0 && addr == 12'h306)
            m_men1 = m_apply(m_men1, op, d) & MASK1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and idle behaviour
        step("R1 reset men", 1, 3, 12'h306, 0, 0);
        step("R1 reset sen", 1, 3, 12'h106, 0, 0);
        step("R1 idle", 0, 2, 12'hC00, 1, 32'hFFFF_FFFF);
        // R2 machine reads with all enables clear
        step("R2 m C00", 1, 3, 12'hC00, 0, 0);
        step("R2 m C1F", 1, 3, 12'hC1F, 0, 0);
        // R3 supervisor needs machine bit
        step("R3 s C00 off", 1, 1, 12'hC00, 0, 0);
        step("R5 u C00 off", 1, 0, 12'hC00, 0, 0);
        step("R9 m write men", 1, 3, 12'h306, 1, 32'h0000_0005);
        step("R11 m read men", 1, 3, 12'h306, 0, 0);
        step("R3 s C00 on", 1, 1, 12'hC00, 0, 0);
        step("R3 s C01 off", 1, 1, 12'hC01, 0, 0);
        step("R3 s C02 on", 1, 1, 12'hC02, 0, 0);
        // R4 / R5 user chain
        step("R4 u C00 no sbit", 1, 0, 12'hC00, 0, 0);
        step("R12 m sen access", 1, 3, 12'h106, 1, 32'h0000_0001);
        step("R4 u C00 both", 1, 0, 12'hC00, 0, 0);
        step("R4 u C02 sbit off", 1, 0, 12'hC02, 0, 0);
        step("R8 s write sen", 1, 1, 12'h106, 2, 32'h0000_0004);
        step("R4 u C02 both", 1, 0, 12'hC02, 0, 0);
        // R7 privilege field
        step("R7 u write sen", 1, 0, 12'h106, 1, 32'hFFFF_FFFF);
        step("R7 s write men", 1, 1, 12'h306, 1, 32'hFFFF_FFFF);
        step("R7 s read F11", 1, 1, 12'hF11, 0, 0);
        step("R7 m read F11", 1, 3, 12'hF11, 0, 0);
        // R6 read-only writes
        step("R6 m write C00", 1, 3, 12'hC00, 1, 32'h1);
        step("R6 m clear C02", 1, 3, 12'hC02, 3, 32'h0);
        step("R6 m set F11", 1, 3, 12'hF11, 2, 32'h0);
        // R8 reserved mode
        step("R8 mode2 read", 1, 2, 12'hC00, 0, 0);
        // R9 set / clear, R10 mask
        step("R9 m set men", 1, 3, 12'h306, 2, 32'hFFFF_0000);
        step("R10 read men", 1, 3, 12'h306, 0, 0);
        step("R9 m clear men", 1, 3, 12'h306, 3, 32'h8000_0001);
        step("R10 read men2", 1, 3, 12'h306, 0, 0);
        step("R10 m write all", 1, 3, 12'h306, 1, 32'hFFFF_FFFF);
        step("R10 read men3", 1, 3, 12'h306, 0, 0);
        step("R5 u C03 masked", 1, 0, 12'hC03, 0, 0);
        step("R5 u C1F", 1, 0, 12'hC1F, 0, 0);
        step("R11 s read sen", 1, 1, 12'h106, 0, 0);
        step("R1 idle2", 0, 3, 12'h306, 1, 32'h0);
        step("R11 m read men4", 1, 3, 12'h306, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule